// File: doc/BRIEF.md
# Gated Write-One-Clear Error Status Register

This block holds the error status word of a card host controller. Each implemented bit latches a one-cycle error event from its detector, but only while the matching status-enable bit is high. Once set, a bit stays set until software writes a 1 to that position through a single-register write port. Writing a 0 leaves the bit as it is.

One bit has no detector pulse of its own. It is set whenever any bit of a 5-bit auto-command error vector goes from 0 to 1. A separate signal-enable mask chooses which latched bits drive the single registered interrupt line. The event detectors and the enable-mask registers sit outside the block.

Top module: `wo1c_err_status`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `sts_o` is 0 and `irq_o` is 0.
- R2: Only bits 0-7, 8, 9 and 12 are implemented (mask 16'h13FF). All other `sts_o` bits always read 0, whatever the inputs. `evt_i[8]` and the `evt_i` bits at unimplemented positions have no effect.
- R3: An event pulse on `evt_i[n]` in cycle k sets `sts_o[n]` from the first rising edge of k onward, if `sts_en_i[n]` is 1 in cycle k. If `sts_en_i[n]` is 0, the bit stays 0.
- R4: A write (`wr_en_i`=1) clears every `sts_o` bit where `wr_data_i` is 1 at that edge. Bits where `wr_data_i` is 0 keep their value.
- R5: If an enabled set and a write-one-clear hit the same bit at the same edge, the bit ends up 1.
- R6: Bit 8 sets at an edge where some bit of `acmd_err_i` is 1 and was 0 at the previous edge (0 after reset), provided `sts_en_i[8]` is 1. A vector held high does not set the bit again after it has been cleared.
- R7: `irq_o` is registered. After each edge it equals the OR over n of (`sts_o[n]` & `sig_en_i[n]`), using the `sts_o` value before that edge and the `sig_en_i` value at that edge. The interrupt therefore follows the status by one cycle.
- R8: Dropping `sts_en_i[n]` to 0 does not clear a bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Per-bit error event pulses |
| acmd_err_i | input | 5 | Auto-command error flags; a rise on any flag sets bit 8 |
| sts_en_i | input | 16 | Status-enable mask: a bit may latch only where this is 1 |
| sig_en_i | input | 16 | Signal-enable mask: selects the bits that drive the interrupt |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; a 1 clears the matching status bit |
| sts_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt, registered |

## Verification
A wrong latch or clear in one bit cell shows up on `sts_o` at the very next edge. The bench compares `sts_o` with a bench-side model every cycle, so such faults are caught within one cycle. A bad interrupt path, such as the wrong mask or a missing register stage, makes `irq_o` differ from the model one edge after the status changes. A stale edge-detector state for the auto-command vector shows up as a missed set or a spurious set on bit 8 after a write clears it while the vector is held high.

// File: rtl/wo1c_err_pkg.sv
package wo1c_err_pkg;
  localparam int unsigned STS_W     = 16;
  localparam int unsigned ACMD_W    = 5;
  localparam int unsigned ACMD_BIT  = 8;
  localparam logic [STS_W-1:0] IMPL_MASK = 16'h13FF;
  localparam logic [STS_W-1:0] EVT_MASK  = IMPL_MASK & ~(STS_W'(1) << ACMD_BIT);
endpackage

// File: rtl/wo1c_rise_det.sv
module wo1c_rise_det #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] vec_i,
  output logic         any_rise_o
);
  logic [W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= vec_i;
  end

  assign any_rise_o = |(vec_i & ~vec_q);

  p_rise_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rise_o |=> (vec_q != '0));
endmodule

// File: rtl/wo1c_sts_bit.sv
module wo1c_sts_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  logic set_g;
  assign set_g = set_i & en_i;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_g)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !(set_i && en_i)) |=> !q_o);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(set_i && en_i)) |=> !q_o);
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && en_i && clr_i) |=> q_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/wo1c_irq_reg.sv
module wo1c_irq_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] sig_en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(sts_i & sig_en_i);
  end

  p_irq_needs_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i == '0) |=> !irq_o);
endmodule

// File: rtl/wo1c_err_status.sv
module wo1c_err_status
  import wo1c_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STS_W-1:0]  evt_i,
  input  logic [ACMD_W-1:0] acmd_err_i,
  input  logic [STS_W-1:0]  sts_en_i,
  input  logic [STS_W-1:0]  sig_en_i,
  input  logic              wr_en_i,
  input  logic [STS_W-1:0]  wr_data_i,
  output logic [STS_W-1:0]  sts_o,
  output logic              irq_o
);
  logic             acmd_rise;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic             unused_in;

  wo1c_rise_det #(.W(ACMD_W)) u_rise (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vec_i      (acmd_err_i),
    .any_rise_o (acmd_rise)
  );

  assign set_vec   = (evt_i & EVT_MASK) | (STS_W'(acmd_rise) << ACMD_BIT);
  assign clr_vec   = wr_en_i ? wr_data_i : '0;
  assign unused_in = ^{evt_i & ~EVT_MASK, clr_vec & ~IMPL_MASK,
                       sts_en_i & ~IMPL_MASK, set_vec & ~IMPL_MASK};

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      wo1c_sts_bit u_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec[i]),
        .en_i   (sts_en_i[i]),
        .clr_i  (clr_vec[i]),
        .q_o    (sts_o[i])
      );
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end

  wo1c_irq_reg #(.W(STS_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sts_i    (sts_o),
    .sig_en_i (sig_en_i),
    .irq_o    (irq_o)
  );

  p_unimpl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o & ~IMPL_MASK) == '0);
  p_acmd_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acmd_rise && sts_en_i[ACMD_BIT]) |=> sts_o[ACMD_BIT]);
  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(sts_o) != '0));
endmodule

// File: tb/wo1c_err_status_test.sv
module wo1c_err_status_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IMPL = 16'h13FF;
  localparam logic [15:0] EVTM = 16'h12FF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic [4:0]  acmd_err_i = '0;
  logic [15:0] sts_en_i = '0;
  logic [15:0] sig_en_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] sts_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_sts = '0;
  logic        m_irq = 1'b0;
  logic [4:0]  m_acmd = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wo1c_err_status uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .acmd_err_i(acmd_err_i),
    .sts_en_i(sts_en_i), .sig_en_i(sig_en_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .sts_o(sts_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] next_sts(logic [15:0] s, logic [15:0] e,
      logic [4:0] a, logic [4:0] ap, logic [15:0] en, logic we, logic [15:0] wd);
    logic [15:0] set_m;
    set_m = (e & EVTM) | ({15'd0, |(a & ~ap)} << 8);
    set_m = set_m & en;
    return ((s & ~(we ? wd : 16'h0)) | set_m) & IMPL;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply inputs at negedge, clock once, update model, compare after edge
  task automatic cyc(input logic [15:0] e, input logic [4:0] a, input logic [15:0] en,
                     input logic [15:0] sg, input logic we, input logic [15:0] wd,
                     input string tag);
    @(negedge clk_i);
    evt_i = e; acmd_err_i = a; sts_en_i = en; sig_en_i = sg; wr_en_i = we; wr_data_i = wd;
    @(posedge clk_i);
    m_irq  = |(m_sts & sg);
    m_sts  = next_sts(m_sts, e, a, m_acmd, en, we, wd);
    m_acmd = a;
    #1;
    chk(sts_o, m_sts, tag);
    chk({15'd0, irq_o}, {15'd0, m_irq}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3);
    chk(sts_o, 16'h0, "R1 in reset");
    chk({15'd0, irq_o}, 16'h0, "R1 irq in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    cyc('0, '0, '0, '0, 1'b0, '0, "R1 after reset");

    // R3 gated: event with enable off
    cyc(16'h0001, '0, 16'h0000, 16'hFFFF, 1'b0, '0, "R3 gated");
    chk(sts_o, 16'h0000, "R3 gated literal");
    // R3 enabled set
    cyc(16'h0003, '0, 16'h0001, 16'hFFFF, 1'b0, '0, "R3 set");
    chk(sts_o, 16'h0001, "R3 set literal");
    // R7 irq one cycle later
    chk({15'd0, irq_o}, 16'h0, "R7 irq lag");
    cyc('0, '0, '0, 16'hFFFF, 1'b0, '0, "R7 irq");
    chk({15'd0, irq_o}, 16'h1, "R7 irq literal");
    // R7 signal enable off masks
    cyc('0, '0, '0, 16'hFFFE, 1'b0, '0, "R7 masked");
    chk({15'd0, irq_o}, 16'h0, "R7 masked literal");
    // R8 dropping status enable keeps bit
    chk(sts_o, 16'h0001, "R8 hold literal");
    // R2 unimplemented and bit 8 event ignored
    cyc(16'hED00, '0, 16'hFFFF, 16'hFFFF, 1'b0, '0, "R2 ignore");
    chk(sts_o, 16'h0001, "R2 ignore literal");
    // R4 write zero no change, then W1C
    cyc('0, '0, '0, '0, 1'b1, 16'h0000, "R4 write0");
    chk(sts_o, 16'h0001, "R4 write0 literal");
    cyc('0, '0, '0, '0, 1'b1, 16'hFFFF, "R4 clear");
    chk(sts_o, 16'h0000, "R4 clear literal");
    // R5 set wins
    cyc(16'h1200, '0, 16'h1200, '0, 1'b1, 16'h1200, "R5 set wins");
    chk(sts_o, 16'h1200, "R5 literal");
    cyc('0, '0, '0, '0, 1'b1, 16'hFFFF, "R4 clear2");
    // R6 rising edge on the vector
    cyc('0, 5'b00100, 16'h0100, '0, 1'b0, '0, "R6 rise");
    chk(sts_o, 16'h0100, "R6 rise literal");
    cyc('0, 5'b00100, 16'h0100, '0, 1'b1, 16'h0100, "R6 held clear");
    chk(sts_o, 16'h0000, "R6 held no reset literal");
    cyc('0, 5'b00110, 16'h0100, '0, 1'b0, '0, "R6 second rise");
    chk(sts_o, 16'h0100, "R6 second rise literal");
    cyc('0, 5'b00000, 16'h0100, '0, 1'b1, 16'h0100, "R6 fall");
    chk(sts_o, 16'h0000, "R6 fall literal");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] e, en, sg, wd;
      logic [4:0] a;
      logic we;
      e  = $urandom & $urandom & $urandom;
      a  = (($urandom % 4) == 0) ? 5'($urandom) : acmd_err_i;
      en = $urandom | $urandom;
      sg = $urandom;
      we = (($urandom % 5) == 0);
      wd = $urandom;
      cyc(e, a, en, sg, we, wd, "R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule